// File: doc/BRIEF.md
# Pin Bank Controller with Set/Clear Output Aliases

This block drives sixteen general-purpose pins from a 32-bit memory-mapped register port. Software picks each pin's direction and output level. Pin levels come back through a synchronizer into a read-only input register. The output level register can be changed in three ways: a plain write, a write-one-to-set alias, or a write-one-to-clear alias. Reading either alias returns the output register itself, not the pin. Each pin is presented to the pad ring as two separate wires, an output enable and an output value, so the block contains no tristate logic.

The register port takes one transaction per cycle. A write takes effect at the clock edge where it is sampled. A read is answered one cycle later by a small response machine with two states:

- `ST_IDLE`: no response pending. It moves to `ST_RESP` when a read is accepted.
- `ST_RESP`: the read data is valid for this cycle. It stays in `ST_RESP` on a back-to-back read and otherwise returns to `ST_IDLE`.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset the direction register reads 0x0000FFFF (all pins input), the output register reads 0, `pad_oe` and `pad_out` are 0, `bus_rvalid` is 0, and the input register reads 0 while the pins are low.
- R2: Direction register at offset 0x10. Bit n = 0 makes pin n an output (`pad_oe[n]` = 1) and bit n = 1 makes it an input (`pad_oe[n]` = 0). The change takes effect at the edge that samples the write.
- R3: Output register at offset 0x14. A write replaces its bits 15:0, and every output pin then drives the written bit on `pad_out`.
- R4: Writing to the set alias at offset 0x18 sets each output bit whose write bit is 1. Write bits that are 0 leave the matching output bits unchanged.
- R5: Writing to the clear alias at offset 0x1C clears each output bit whose write bit is 1. Write bits that are 0 leave the matching output bits unchanged.
- R6: A read of offset 0x18 or 0x1C returns the output register, not the pin levels.
- R7: For a pin set as input, `pad_oe` is 0 and `pad_out` is 0, whatever the output register holds. Writes through 0x14, 0x18 or 0x1C still update the output register, and it reads back.
- R8: The input register at offset 0x20 returns the pin levels after a two-flop synchronizer, for input and output pins alike. A read sampled at the second edge after a pin change still returns the old level. A read sampled at the third edge returns the new level.
- R9: Only bits 15:0 are implemented. Bits 31:16 of every read are 0, and bits 31:16 of every write are ignored.
- R10: A read of any offset other than 0x10, 0x14, 0x18, 0x1C and 0x20 (including unaligned ones) returns 0. A write to such an offset changes no register.
- R11: `bus_rvalid` is high for exactly the cycle after each accepted read and is low otherwise. `bus_rdata` is 0 whenever `bus_rvalid` is low.
- R12: A write to the input register offset 0x20 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Transaction request, one per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the read |
| pin_in | input | 16 | Level seen at each pad |
| pad_oe | output | 16 | Per-pin output driver enable |
| pad_out | output | 16 | Per-pin driven value |

## Verification
The bench builds the block with its default parameters: sixteen pins, a 32-bit data path, an 8-bit offset and two synchronizer stages. Because the pin count is half the data width, the reserved upper half-word can be written with all ones and checked to read back as zero. The synchronizer depth of two lets three back-to-back reads straddle a pin change and show the exact cycle where the new level first appears. The bench models each pad as driven by the block when `pad_oe` is set and by the bench otherwise, so a read of the input register returns a mix of looped-back outputs and external inputs.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Register offsets; software depends on these values
    localparam logic [7:0] OFF_DIR = 8'h10;
    localparam logic [7:0] OFF_OUT = 8'h14;
    localparam logic [7:0] OFF_SET = 8'h18;
    localparam logic [7:0] OFF_CLR = 8'h1C;
    localparam logic [7:0] OFF_IN  = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_OUT,
        SEL_SET,
        SEL_CLR,
        SEL_IN
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rsp_state_e;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == AW'(OFF_DIR))      sel = SEL_DIR;
        else if (addr == AW'(OFF_OUT)) sel = SEL_OUT;
        else if (addr == AW'(OFF_SET)) sel = SEL_SET;
        else if (addr == AW'(OFF_CLR)) sel = SEL_CLR;
        else if (addr == AW'(OFF_IN))  sel = SEL_IN;
    end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] out_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR: dir_q <= wdata;
                SEL_OUT: out_q <= wdata;
                SEL_SET: out_q <= out_q | wdata;
                SEL_CLR: out_q <= out_q & ~wdata;
                default: ;
            endcase
        end
    end

    // R4
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R5
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=> ((out_q & $past(wdata)) == '0));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(out_q) && $stable(dir_q)));

    // R12
    in_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_IN) |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int DW          = 32,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_rvalid,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out
);

    localparam int PAD_W = DW - NPINS;

    reg_sel_e         sel;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] in_sync;
    logic [DW-1:0]    rd_mux;
    logic [DW-1:0]    rdata_q;
    logic             rd_acc;
    logic             wr_acc;
    rsp_state_e       state_q;
    rsp_state_e       state_d;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = &{1'b0, bus_wdata[DW-1:NPINS]};
    assign rd_acc = bus_req && !bus_wr;
    assign wr_acc = bus_req && bus_wr;

    pinbank_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    pinbank_regs #(.NPINS(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_acc),
        .sel   (sel),
        .wdata (bus_wdata[NPINS-1:0]),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (in_sync)
    );

    // Pad drive: a pin is driven only when its direction bit is 0
    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pad
            assign pad_oe[p]  = ~dir_q[p];
            assign pad_out[p] = dir_q[p] ? 1'b0 : out_q[p];
        end
    endgenerate

    // Read-back selection; both aliases return the output register
    always_comb begin
        case (sel)
            SEL_DIR:                   rd_mux = {{PAD_W{1'b0}}, dir_q};
            SEL_OUT, SEL_SET, SEL_CLR: rd_mux = {{PAD_W{1'b0}}, out_q};
            SEL_IN:                    rd_mux = {{PAD_W{1'b0}}, in_sync};
            default:                   rd_mux = '0;
        endcase
    end

    // Response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;
        endcase
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rvalid = (state_q == ST_RESP);
    assign bus_rdata  = bus_rvalid ? rdata_q : '0;

    // R2
    dir_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && sel == SEL_DIR) |=> (pad_oe == ~$past(bus_wdata[NPINS-1:0])));

    // R7
    input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    // R11
    rsp_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);

    // R11
    rsp_only_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !bus_rvalid);

    // R11
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

    // R9
    rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:NPINS] == '0);

endmodule

// File: tb/sim_pinbank_ctrl.sv
module sim_pinbank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] pin_in;
    logic [15:0] pad_oe;
    logic [15:0] pad_out;
    logic [15:0] ext_lvl = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    // Pad model: the block drives a pin when enabled, the bench otherwise
    always_comb begin
        for (int i = 0; i < 16; i++)
            pin_in[i] = pad_oe[i] ? pad_out[i] : ext_lvl[i];
    end

    pinbank_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pin_in     (pin_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Driver: pushes the expected response, then issues the read
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // Monitor: compares each response with the head of the queue
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (bus_rvalid) begin
                if (q_exp.size() == 0) begin
                    check("R11 unexpected response", bus_rdata, 32'hxxxx_xxxx);
                end else begin
                    check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
                end
            end else if (bus_rdata !== 32'h0) begin
                check("R11 rdata idle", bus_rdata, 32'h0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        check("R1 pad_out", {16'h0, pad_out}, 32'h0);
        check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
        bus_read(8'h10, 32'h0000_FFFF, "R1 dir reset");
        bus_read(8'h14, 32'h0, "R1 out reset");
        bus_read(8'h20, 32'h0, "R1 in reset");
        @(negedge clk);

        // R7 output writes while all pins are inputs
        bus_write(8'h14, 32'h0000_00A5);
        check("R7 pad_oe input", {16'h0, pad_oe}, 32'h0);
        check("R7 pad_out input", {16'h0, pad_out}, 32'h0);
        bus_read(8'h14, 32'h0000_00A5, "R7 R3 out readback");

        // R2 R3 low byte becomes output
        bus_write(8'h10, 32'h0000_FF00);
        check("R2 pad_oe", {16'h0, pad_oe}, 32'h0000_00FF);
        check("R3 pad_out", {16'h0, pad_out}, 32'h0000_00A5);
        // R11 no response after a write
        check("R11 no rvalid after write", {31'h0, bus_rvalid}, 32'h0);

        // R4 set alias
        bus_write(8'h18, 32'h0000_0102);
        check("R4 R7 pad_out after set", {16'h0, pad_out}, 32'h0000_00A7);
        bus_read(8'h18, 32'h0000_01A7, "R6 R4 set alias read");

        // R5 clear alias
        bus_write(8'h1C, 32'h0000_0021);
        check("R5 pad_out after clear", {16'h0, pad_out}, 32'h0000_0086);
        bus_read(8'h1C, 32'h0000_0186, "R6 R5 clear alias read");

        // R4 R5 zero bits have no effect
        bus_write(8'h18, 32'h0);
        bus_write(8'h1C, 32'h0);
        check("R4 R5 zero write pad_out", {16'h0, pad_out}, 32'h0000_0086);
        bus_read(8'h14, 32'h0000_0186, "R4 R5 zero write out");

        // R9 upper bits ignored and read as zero
        bus_write(8'h10, 32'hFFFF_0F0F);
        bus_read(8'h10, 32'h0000_0F0F, "R9 dir upper bits");
        bus_write(8'h14, 32'hFFFF_1234);
        bus_read(8'h14, 32'h0000_1234, "R9 out upper bits");
        check("R2 pad_oe mixed", {16'h0, pad_oe}, 32'h0000_F0F0);
        check("R3 pad_out mixed", {16'h0, pad_out}, 32'h0000_1030);

        // R10 unmapped offsets
        bus_write(8'h24, 32'h0000_FFFF);
        bus_write(8'h08, 32'h0000_FFFF);
        bus_write(8'h11, 32'h0000_FFFF);
        bus_read(8'h24, 32'h0, "R10 unmapped 0x24");
        bus_read(8'h00, 32'h0, "R10 unmapped 0x00");
        bus_read(8'h11, 32'h0, "R10 unaligned 0x11");
        bus_read(8'h10, 32'h0000_0F0F, "R10 dir intact");
        bus_read(8'h14, 32'h0000_1234, "R10 out intact");

        // R12 write to input register ignored
        bus_write(8'h20, 32'h0000_FFFF);
        bus_read(8'h10, 32'h0000_0F0F, "R12 dir intact");
        bus_read(8'h14, 32'h0000_1234, "R12 out intact");

        // R8 input sync latency; pins = (out & ~dir) | (ext & dir)
        // before: ext=0 -> 0x1030 ; after: ext=0x5A5A -> 0x1030 | 0x0A0A = 0x1A3A
        ext_lvl = 16'h5A5A;
        bus_read(8'h20, 32'h0000_1030, "R8 old level edge1");
        bus_read(8'h20, 32'h0000_1030, "R8 old level edge2");
        bus_read(8'h20, 32'h0000_1A3A, "R8 new level edge3");
        repeat (2) @(negedge clk);

        // R8 loopback with all pins output
        bus_write(8'h10, 32'h0);
        repeat (3) @(negedge clk);
        bus_read(8'h20, 32'h0000_1234, "R8 loopback outputs");

        // R2 back to all inputs
        bus_write(8'h10, 32'h0000_FFFF);
        check("R2 all input pad_oe", {16'h0, pad_oe}, 32'h0);
        repeat (4) @(negedge clk);
        bus_read(8'h20, 32'h0000_5A5A, "R8 external levels");
        repeat (3) @(negedge clk);

        check("R11 all responses seen", q_exp.size(), 32'h0);
        finish_run();
    end

endmodule